// File: doc/BRIEF.md
# Paged NIC Register File

This block is the byte-wide host register interface of a legacy Ethernet controller. The host reaches it through a 5-bit offset, a write strobe with write data, and a read data bus that always shows the register selected by the current offset. Offset 0 is always the command register. The top two command bits choose one of four pages, and that page decides what offsets 1 to 15 mean. The block holds the following state:
- the receive-ring page pointers
- the transmit page start and the transmit byte count
- the remote-DMA start address and byte count
- the receive, transmit and data configuration bytes
- the station address and the multicast mask
- the interrupt status and mask registers

Beyond holding registers, the block acts on command writes. It clears the power-on reset indication and reports that a remote DMA with a zero byte count has already finished. A transmit command starts a send: the block emits a one-cycle request that carries the buffer byte address and the byte count. A single interrupt output follows the masked interrupt status. Packet memory, the MAC and the network side lie outside this block.

Top module: `nic_regfile`

## Requirements
- R1: Reset values are as follows. Command is 0x22 and the interrupt mask is 0x00. Interrupt status is 0x80, where bit 7 is the reset indication. All 8 multicast bytes are 0xFF. Every other register is 0x00. irq and tx_req are low.
- R2: Offset 0 reads and writes the command register on every page, and command bits [7:6] select the page for offsets 1-15. Offsets 16-31 and all of page 3 except offset 0 read 0x00 and ignore writes. Registers change on the clock edge that samples wr_en, and rdata reflects the current state and offset without delay.
- R3: On page 0, writes to the following offsets load these registers:

  | Offset | Register |
  |---|---|
  | 1 | ring start page |
  | 2 | ring stop page |
  | 3 | boundary |
  | 4 | transmit page |
  | 5 / 6 | transmit count, low / high byte |
  | 7 | interrupt status, write-1-to-clear |
  | 8 / 9 | remote address, low / high byte |
  | 10 / 11 | remote count, low / high byte |
  | 12 | receive configuration |
  | 13 | transmit configuration |
  | 14 | data configuration |
  | 15 | interrupt mask |

  Page 0 reads return the boundary at offset 3, the transmit status at offset 4 and the interrupt status at offset 7. All other page 0 offsets read 0x00.
- R4: Page 1 reads and writes the 6 station address bytes at offsets 1-6, the current page at offset 7, and the 8 multicast bytes at offsets 8-15.
- R5: Page 2 ignores writes to offsets 1-15 and reads back these registers:

  | Offset | Register |
  |---|---|
  | 1 | ring start page |
  | 2 | ring stop page |
  | 4 | transmit page |
  | 5 / 6 | transmit count, low / high byte |
  | 8 / 9 | remote address, low / high byte |
  | 10 / 11 | remote count, low / high byte |
  | 12 | receive configuration |
  | 13 | transmit configuration |
  | 14 | data configuration |
  | 15 | interrupt mask |

  Offsets 3 and 7 read 0x00.
- R6: Each 16-bit count and the remote address take low-byte and high-byte writes separately, and each write leaves the other byte unchanged.
- R7: Writing interrupt status clears each of bits [6:0] that is written as 1. Bit 7 is not affected by such writes.
- R8: irq is high exactly when (status AND mask AND 0x7F) is nonzero. It follows a register write by one clock edge.
- R9: A command write with bit 0 (stop) clear drops status bit 7. A command write with bit 0 set leaves status bit 7 unchanged.
- R10: A command write meets three conditions: bit 0 is clear, bit 3 (remote read) or bit 4 (remote write) is set, and the remote count is zero. Such a write sets status bit 6. With a nonzero count it does not.
- R11: A command write with bit 0 clear and bit 2 (transmit) set has these effects after the next edge:
  - tx_req goes high for one cycle.
  - tx_addr becomes the transmit page shifted left by 8, and tx_len becomes the transmit count.
  - The transmit status becomes 0x01 and status bit 1 is set.
  - The stored command bit 2 reads back as 0.

  tx_addr and tx_len hold their values until the next send. With bit 0 set, a transmit command issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset and page |
| irq | output | 1 | Interrupt request |
| tx_req | output | 1 | One-cycle transmit start pulse |
| tx_addr | output | 16 | Byte address of the frame to send |
| tx_len | output | 16 | Byte count of the frame to send |

## Verification
Status bit 7 is the hardest case to reach from the ports. It is set only by reset, and the first command write with stop clear erases it. Its immunity to status writes and to stop-set commands therefore has to be tested early in each run. The stimulus first walks pages 1, 2 and 3 using command values with the stop bit held at 1, and only then issues a start command. It forces a reset partway through to get back to that state. The remote-DMA completion case needs the remote count to be exactly zero, so the bench tests it before loading a nonzero low count and then repeats the command.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

    localparam int DATA_W  = 8;
    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 5;
    localparam int NUM_STA = 6;
    localparam int NUM_MC  = 8;
    localparam int IDX_W   = (NUM_MC > NUM_STA) ? $clog2(NUM_MC) : $clog2(NUM_STA);

    // command bit positions
    localparam int CB_STOP = 0;
    localparam int CB_TX   = 2;
    localparam int CB_RRD  = 3;
    localparam int CB_RWR  = 4;

    // interrupt status bit positions
    localparam int IS_TXOK = 1;
    localparam int IS_RDC  = 6;
    localparam int IS_RST  = 7;

    localparam logic [DATA_W-1:0] CMD_INIT  = 8'h22;
    localparam logic [DATA_W-1:0] ISR_INIT  = 8'h80;
    localparam logic [DATA_W-1:0] MC_INIT   = 8'hFF;
    localparam logic [DATA_W-1:0] TSR_SENT  = 8'h01;
    localparam logic [DATA_W-1:0] ISR_WMASK = 8'h7F;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_CMD, SEL_PSTART, SEL_PSTOP, SEL_BOUND, SEL_TPAGE,
        SEL_TSTAT, SEL_TCNT_L, SEL_TCNT_H, SEL_ISR, SEL_RADR_L, SEL_RADR_H,
        SEL_RCNT_L, SEL_RCNT_H, SEL_RXCFG, SEL_TXCFG, SEL_DCFG, SEL_IMR,
        SEL_STA, SEL_CUR, SEL_MC
    } sel_e;

    typedef struct packed {
        logic [DATA_W-1:0]              cmd;
        logic [DATA_W-1:0]              pstart;
        logic [DATA_W-1:0]              pstop;
        logic [DATA_W-1:0]              bound;
        logic [DATA_W-1:0]              tpage;
        logic [DATA_W-1:0]              tstat;
        logic [CNT_W-1:0]               tcnt;
        logic [CNT_W-1:0]               radr;
        logic [CNT_W-1:0]               rcnt;
        logic [DATA_W-1:0]              rxcfg;
        logic [DATA_W-1:0]              txcfg;
        logic [DATA_W-1:0]              dcfg;
        logic [DATA_W-1:0]              imr;
        logic [DATA_W-1:0]              isr;
        logic [DATA_W-1:0]              cur;
        logic [NUM_STA-1:0][DATA_W-1:0] sta;
        logic [NUM_MC-1:0][DATA_W-1:0]  mc;
    } regs_t;

    typedef struct packed {
        logic             req;
        logic [CNT_W-1:0] addr;
        logic [CNT_W-1:0] len;
    } txo_t;

    function automatic regs_t regs_init();
        regs_t r;
        r     = '0;
        r.cmd = CMD_INIT;
        r.isr = ISR_INIT;
        for (int i = 0; i < NUM_MC; i++) r.mc[i] = MC_INIT;
        return r;
    endfunction

endpackage

// File: rtl/nic_page_decode.sv
module nic_page_decode
    import nic_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        page,
    output sel_e              wr_sel,
    output sel_e              rd_sel,
    output logic [IDX_W-1:0]  idx
);
    localparam int LO_W = 4;

    logic [LO_W-1:0] lo;
    logic            hi_zero;

    assign lo      = addr[LO_W-1:0];
    assign hi_zero = (addr[ADDR_W-1:LO_W] == '0);

    always_comb begin
        wr_sel = SEL_NONE;
        rd_sel = SEL_NONE;
        idx    = '0;
        if (hi_zero && lo == 4'd0) begin
            wr_sel = SEL_CMD;
            rd_sel = SEL_CMD;
        end else if (hi_zero) begin
            case (page)
                2'd0: begin
                    case (lo)
                        4'd1:  wr_sel = SEL_PSTART;
                        4'd2:  wr_sel = SEL_PSTOP;
                        4'd3:  begin wr_sel = SEL_BOUND; rd_sel = SEL_BOUND; end
                        4'd4:  begin wr_sel = SEL_TPAGE; rd_sel = SEL_TSTAT; end
                        4'd5:  wr_sel = SEL_TCNT_L;
                        4'd6:  wr_sel = SEL_TCNT_H;
                        4'd7:  begin wr_sel = SEL_ISR; rd_sel = SEL_ISR; end
                        4'd8:  wr_sel = SEL_RADR_L;
                        4'd9:  wr_sel = SEL_RADR_H;
                        4'd10: wr_sel = SEL_RCNT_L;
                        4'd11: wr_sel = SEL_RCNT_H;
                        4'd12: wr_sel = SEL_RXCFG;
                        4'd13: wr_sel = SEL_TXCFG;
                        4'd14: wr_sel = SEL_DCFG;
                        default: wr_sel = SEL_IMR;
                    endcase
                end
                2'd1: begin
                    if (lo <= 4'd6) begin
                        wr_sel = SEL_STA;
                        idx    = IDX_W'(lo - 4'd1);
                    end else if (lo == 4'd7) begin
                        wr_sel = SEL_CUR;
                    end else begin
                        wr_sel = SEL_MC;
                        idx    = IDX_W'(lo - 4'd8);
                    end
                    rd_sel = wr_sel;
                end
                2'd2: begin
                    case (lo)
                        4'd1:  rd_sel = SEL_PSTART;
                        4'd2:  rd_sel = SEL_PSTOP;
                        4'd4:  rd_sel = SEL_TPAGE;
                        4'd5:  rd_sel = SEL_TCNT_L;
                        4'd6:  rd_sel = SEL_TCNT_H;
                        4'd8:  rd_sel = SEL_RADR_L;
                        4'd9:  rd_sel = SEL_RADR_H;
                        4'd10: rd_sel = SEL_RCNT_L;
                        4'd11: rd_sel = SEL_RCNT_H;
                        4'd12: rd_sel = SEL_RXCFG;
                        4'd13: rd_sel = SEL_TXCFG;
                        4'd14: rd_sel = SEL_DCFG;
                        4'd15: rd_sel = SEL_IMR;
                        default: rd_sel = SEL_NONE;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // R2: offset 0 selects the command register whatever the page
    always_comb begin
        if (addr == '0) begin
            a_r2_cmd_all_pages: assert (wr_sel == SEL_CMD && rd_sel == SEL_CMD);
        end
    end
endmodule

// File: rtl/nic_cmd_effects.sv
module nic_cmd_effects (
    input  logic stop_bit,
    input  logic tx_bit,
    input  logic rrd_bit,
    input  logic rwr_bit,
    input  logic rcnt_zero,
    output logic run,
    output logic rdc_set,
    output logic tx_go
);
    always_comb begin
        run     = !stop_bit;
        rdc_set = run && (rrd_bit || rwr_bit) && rcnt_zero;
        tx_go   = run && tx_bit;
    end
endmodule

// File: rtl/nic_read_mux.sv
module nic_read_mux
    import nic_regs_pkg::*;
(
    input  sel_e              rd_sel,
    input  logic [IDX_W-1:0]  idx,
    input  regs_t             st,
    output logic [DATA_W-1:0] rdata
);
    localparam int STA_IW = $clog2(NUM_STA);
    localparam int MC_IW  = $clog2(NUM_MC);

    always_comb begin
        case (rd_sel)
            SEL_CMD:    rdata = st.cmd;
            SEL_PSTART: rdata = st.pstart;
            SEL_PSTOP:  rdata = st.pstop;
            SEL_BOUND:  rdata = st.bound;
            SEL_TPAGE:  rdata = st.tpage;
            SEL_TSTAT:  rdata = st.tstat;
            SEL_TCNT_L: rdata = st.tcnt[DATA_W-1:0];
            SEL_TCNT_H: rdata = st.tcnt[CNT_W-1:DATA_W];
            SEL_ISR:    rdata = st.isr;
            SEL_RADR_L: rdata = st.radr[DATA_W-1:0];
            SEL_RADR_H: rdata = st.radr[CNT_W-1:DATA_W];
            SEL_RCNT_L: rdata = st.rcnt[DATA_W-1:0];
            SEL_RCNT_H: rdata = st.rcnt[CNT_W-1:DATA_W];
            SEL_RXCFG:  rdata = st.rxcfg;
            SEL_TXCFG:  rdata = st.txcfg;
            SEL_DCFG:   rdata = st.dcfg;
            SEL_IMR:    rdata = st.imr;
            SEL_STA:    rdata = st.sta[idx[STA_IW-1:0]];
            SEL_CUR:    rdata = st.cur;
            SEL_MC:     rdata = st.mc[idx[MC_IW-1:0]];
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              tx_req,
    output logic [CNT_W-1:0]  tx_addr,
    output logic [CNT_W-1:0]  tx_len
);
    localparam int STA_IW = $clog2(NUM_STA);
    localparam int MC_IW  = $clog2(NUM_MC);

    regs_t            regs_d, regs_q;
    txo_t             txo_d, txo_q;
    sel_e             wr_sel, rd_sel;
    logic [IDX_W-1:0] idx;
    logic             cmd_run, cmd_rdc, cmd_tx;

    nic_page_decode u_dec (
        .addr   (addr),
        .page   (regs_q.cmd[7:6]),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel),
        .idx    (idx)
    );

    nic_cmd_effects u_cmd (
        .stop_bit  (wdata[CB_STOP]),
        .tx_bit    (wdata[CB_TX]),
        .rrd_bit   (wdata[CB_RRD]),
        .rwr_bit   (wdata[CB_RWR]),
        .rcnt_zero (regs_q.rcnt == '0),
        .run       (cmd_run),
        .rdc_set   (cmd_rdc),
        .tx_go     (cmd_tx)
    );

    nic_read_mux u_rd (
        .rd_sel (rd_sel),
        .idx    (idx),
        .st     (regs_q),
        .rdata  (rdata)
    );

    always_comb begin
        regs_d     = regs_q;
        txo_d      = txo_q;
        txo_d.req  = 1'b0;
        if (wr_en) begin
            case (wr_sel)
                SEL_CMD: begin
                    regs_d.cmd = wdata;
                    if (cmd_run) regs_d.isr[IS_RST] = 1'b0;
                    if (cmd_rdc) regs_d.isr[IS_RDC] = 1'b1;
                    if (cmd_tx) begin
                        txo_d.req              = 1'b1;
                        txo_d.addr             = {regs_q.tpage, {DATA_W{1'b0}}};
                        txo_d.len              = regs_q.tcnt;
                        regs_d.tstat           = TSR_SENT;
                        regs_d.isr[IS_TXOK]    = 1'b1;
                        regs_d.cmd[CB_TX]      = 1'b0;
                    end
                end
                SEL_PSTART: regs_d.pstart = wdata;
                SEL_PSTOP:  regs_d.pstop  = wdata;
                SEL_BOUND:  regs_d.bound  = wdata;
                SEL_TPAGE:  regs_d.tpage  = wdata;
                SEL_TCNT_L: regs_d.tcnt[DATA_W-1:0]     = wdata;
                SEL_TCNT_H: regs_d.tcnt[CNT_W-1:DATA_W] = wdata;
                SEL_ISR:    regs_d.isr = regs_q.isr & ~(wdata & ISR_WMASK);
                SEL_RADR_L: regs_d.radr[DATA_W-1:0]     = wdata;
                SEL_RADR_H: regs_d.radr[CNT_W-1:DATA_W] = wdata;
                SEL_RCNT_L: regs_d.rcnt[DATA_W-1:0]     = wdata;
                SEL_RCNT_H: regs_d.rcnt[CNT_W-1:DATA_W] = wdata;
                SEL_RXCFG:  regs_d.rxcfg = wdata;
                SEL_TXCFG:  regs_d.txcfg = wdata;
                SEL_DCFG:   regs_d.dcfg  = wdata;
                SEL_IMR:    regs_d.imr   = wdata;
                SEL_STA:    regs_d.sta[idx[STA_IW-1:0]] = wdata;
                SEL_CUR:    regs_d.cur   = wdata;
                SEL_MC:     regs_d.mc[idx[MC_IW-1:0]]   = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= regs_init();
            txo_q  <= '0;
        end else begin
            regs_q <= regs_d;
            txo_q  <= txo_d;
        end
    end

    assign irq     = |(regs_q.isr & regs_q.imr & ISR_WMASK);
    assign tx_req  = txo_q.req;
    assign tx_addr = txo_q.addr;
    assign tx_len  = txo_q.len;

    // R7: written ones leave no status bit set in [6:0]
    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ISR) |=> ((regs_q.isr[6:0] & $past(wdata[6:0])) == 7'd0));

    // R9: running command drops the reset indication
    a_r9_rst_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CMD && !wdata[CB_STOP]) |=> !regs_q.isr[IS_RST]);

    // R10: remote DMA with zero count completes at once
    a_r10_rdc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CMD && !wdata[CB_STOP] &&
         (wdata[CB_RRD] || wdata[CB_RWR]) && regs_q.rcnt == '0) |=> regs_q.isr[IS_RDC]);

    // R11: a send request comes with its status effects
    a_r11_tx_effects: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (regs_q.isr[IS_TXOK] && !regs_q.cmd[CB_TX] && regs_q.tstat == TSR_SENT));

    // R11: a send request is never raised without a command write
    a_r11_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !tx_req);

    // R8: nothing can interrupt while the low mask bits are clear
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.imr[6:0] == 7'd0) |-> !irq);

    // R2: without a write strobe the register state holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));
endmodule

// File: tb/nic_regfile_tb.sv
module nic_regfile_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq, tx_req;
    logic [15:0] tx_addr, tx_len;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] v;

    always #(CLK_P/2) clk = ~clk;

    nic_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len)
    );

    // behavioural reference state
    logic [7:0]  m_cmd, m_pst, m_psp, m_bnd, m_tpg, m_tst, m_isr, m_imr;
    logic [7:0]  m_rxc, m_txc, m_dcf, m_cur;
    logic [15:0] m_tcn, m_rad, m_rcn, m_txa, m_txl;
    logic        m_txr;
    logic [7:0]  m_sta [6];
    logic [7:0]  m_mc  [8];

    task automatic m_reset();
        m_cmd = 8'h22; m_isr = 8'h80; m_imr = 0;
        m_pst = 0; m_psp = 0; m_bnd = 0; m_tpg = 0; m_tst = 0;
        m_rxc = 0; m_txc = 0; m_dcf = 0; m_cur = 0;
        m_tcn = 0; m_rad = 0; m_rcn = 0; m_txa = 0; m_txl = 0; m_txr = 0;
        for (int i = 0; i < 6; i++) m_sta[i] = 8'h00;
        for (int i = 0; i < 8; i++) m_mc[i] = 8'hFF;
    endtask

    function automatic logic [7:0] m_read(input int a);
        if (a == 0) return m_cmd;
        if (a > 15) return 8'h00;
        if (m_cmd[7:6] == 2'd0) begin
            if (a == 3) return m_bnd;
            if (a == 4) return m_tst;
            if (a == 7) return m_isr;
            return 8'h00;
        end
        if (m_cmd[7:6] == 2'd1) begin
            if (a <= 6) return m_sta[a-1];
            if (a == 7) return m_cur;
            return m_mc[a-8];
        end
        if (m_cmd[7:6] == 2'd2) begin
            case (a)
                1: return m_pst;  2: return m_psp;  4: return m_tpg;
                5: return m_tcn[7:0];  6: return m_tcn[15:8];
                8: return m_rad[7:0];  9: return m_rad[15:8];
                10: return m_rcn[7:0]; 11: return m_rcn[15:8];
                12: return m_rxc; 13: return m_txc; 14: return m_dcf; 15: return m_imr;
                default: return 8'h00;
            endcase
        end
        return 8'h00;
    endfunction

    task automatic m_step(input logic we, input int a, input logic [7:0] d);
        m_txr = 0;
        if (!we) return;
        if (a == 0) begin
            m_cmd = d;
            if (!d[0]) begin
                m_isr[7] = 0;
                if ((d[3] || d[4]) && m_rcn == 0) m_isr[6] = 1;
                if (d[2]) begin
                    m_txr = 1; m_txa = {m_tpg, 8'h00}; m_txl = m_tcn;
                    m_tst = 8'h01; m_isr[1] = 1; m_cmd[2] = 0;
                end
            end
        end else if (a < 16) begin
            if (m_cmd[7:6] == 2'd0) begin
                case (a)
                    1: m_pst = d; 2: m_psp = d; 3: m_bnd = d; 4: m_tpg = d;
                    5: m_tcn[7:0] = d; 6: m_tcn[15:8] = d;
                    7: m_isr = m_isr & ~{1'b0, d[6:0]};
                    8: m_rad[7:0] = d; 9: m_rad[15:8] = d;
                    10: m_rcn[7:0] = d; 11: m_rcn[15:8] = d;
                    12: m_rxc = d; 13: m_txc = d; 14: m_dcf = d;
                    default: m_imr = d;
                endcase
            end else if (m_cmd[7:6] == 2'd1) begin
                if (a <= 6) m_sta[a-1] = d;
                else if (a == 7) m_cur = d;
                else m_mc[a-8] = d;
            end
        end
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive at the falling edge, compare read data before the
    // rising edge and the registered outputs at the next falling edge
    task automatic cyc(input logic we, input logic [4:0] a, input logic [7:0] d);
        wr_en = we; addr = a; wdata = d;
        #1;
        chk("R2 rdata", {8'h00, rdata}, {8'h00, m_read(int'(a))});
        @(posedge clk);
        m_step(we, int'(a), d);
        @(negedge clk);
        chk("R8 irq", {15'd0, irq}, {15'd0, ((m_isr & m_imr & 8'h7F) != 0)});
        chk("R11 tx_req", {15'd0, tx_req}, {15'd0, m_txr});
        chk("R11 tx_addr", tx_addr, m_txa);
        chk("R11 tx_len", tx_len, m_txl);
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] val);
        wr_en = 0; addr = a; wdata = 0;
        #1 val = rdata;
        cyc(1'b0, a, 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr_en = 0;
        repeat (2) @(negedge clk);
        m_reset();
        rst_n = 1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        m_reset();
        do_reset();
        // R1 reset state
        rd(5'd0, v); chk("R1 cmd", {8'h0, v}, 16'h22);
        rd(5'd7, v); chk("R1 isr", {8'h0, v}, 16'h80);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 tx_req", {15'd0, tx_req}, 16'd0);
        // R7 bit 7 untouched by status writes, R8 bit 7 never interrupts
        cyc(1, 5'd15, 8'h7F);
        cyc(1, 5'd7, 8'hFF);
        rd(5'd7, v); chk("R7 isr bit7 kept", {8'h0, v}, 16'h80);
        chk("R8 bit7 masked", {15'd0, irq}, 16'd0);
        // R4 page 1, stop kept set
        cyc(1, 5'd0, 8'h61);
        rd(5'd8, v);  chk("R1 mc0", {8'h0, v}, 16'hFF);
        rd(5'd15, v); chk("R1 mc7", {8'h0, v}, 16'hFF);
        for (int i = 1; i <= 6; i++) cyc(1, 5'(i), 8'(8'h10 + i));
        cyc(1, 5'd7, 8'h46);
        cyc(1, 5'd9, 8'h5A);
        rd(5'd3, v); chk("R4 sta2", {8'h0, v}, 16'h13);
        rd(5'd7, v); chk("R4 cur", {8'h0, v}, 16'h46);
        rd(5'd9, v); chk("R4 mc1", {8'h0, v}, 16'h5A);
        rd(5'd8, v); chk("R4 mc0", {8'h0, v}, 16'hFF);
        // R5 page 2 read-only
        cyc(1, 5'd0, 8'hA1);
        rd(5'd15, v); chk("R5 imr", {8'h0, v}, 16'h7F);
        cyc(1, 5'd1, 8'h33);
        rd(5'd1, v); chk("R5 write ignored", {8'h0, v}, 16'h00);
        // R2 page 3 unmapped
        cyc(1, 5'd0, 8'hE1);
        cyc(1, 5'd7, 8'h99);
        rd(5'd7, v); chk("R2 page3", {8'h0, v}, 16'h00);
        rd(5'd0, v); chk("R2 cmd page3", {8'h0, v}, 16'hE1);
        // R3 page 0 writes, R6 byte-wise counts
        cyc(1, 5'd0, 8'h21);
        cyc(1, 5'd1, 8'h40); cyc(1, 5'd2, 8'h80); cyc(1, 5'd3, 8'h41);
        cyc(1, 5'd4, 8'h12); cyc(1, 5'd5, 8'h3C); cyc(1, 5'd6, 8'h01);
        cyc(1, 5'd5, 8'h40);
        cyc(1, 5'd8, 8'h34); cyc(1, 5'd9, 8'h12); cyc(1, 5'd8, 8'h78);
        cyc(1, 5'd12, 8'h0C); cyc(1, 5'd19, 8'h55);
        rd(5'd3, v);  chk("R3 boundary", {8'h0, v}, 16'h41);
        rd(5'd1, v);  chk("R3 write-only", {8'h0, v}, 16'h00);
        rd(5'd16, v); chk("R2 high offset", {8'h0, v}, 16'h00);
        rd(5'd7, v);  chk("R9 stop keeps bit7", {8'h0, v}, 16'h80);
        cyc(1, 5'd0, 8'hA1);
        rd(5'd1, v);  chk("R5 pstart", {8'h0, v}, 16'h40);
        rd(5'd4, v);  chk("R5 tpage", {8'h0, v}, 16'h12);
        rd(5'd5, v);  chk("R6 tcnt lo", {8'h0, v}, 16'h40);
        rd(5'd6, v);  chk("R6 tcnt hi", {8'h0, v}, 16'h01);
        rd(5'd8, v);  chk("R6 radr lo", {8'h0, v}, 16'h78);
        rd(5'd9, v);  chk("R6 radr hi", {8'h0, v}, 16'h12);
        rd(5'd12, v); chk("R5 rxcfg", {8'h0, v}, 16'h0C);
        // R9 start drops bit 7
        cyc(1, 5'd0, 8'h22);
        rd(5'd7, v); chk("R9 bit7 dropped", {8'h0, v}, 16'h00);
        // R10 remote DMA with zero count
        cyc(1, 5'd0, 8'h0A);
        rd(5'd7, v); chk("R10 rdc set", {8'h0, v}, 16'h40);
        chk("R8 irq high", {15'd0, irq}, 16'd1);
        cyc(1, 5'd7, 8'h40);
        rd(5'd7, v); chk("R7 cleared", {8'h0, v}, 16'h00);
        chk("R8 irq low", {15'd0, irq}, 16'd0);
        cyc(1, 5'd10, 8'h05);
        cyc(1, 5'd0, 8'h12);
        rd(5'd7, v); chk("R10 nonzero count", {8'h0, v}, 16'h00);
        // R11 transmit
        cyc(1, 5'd0, 8'h26);
        chk("R11 pulse", {15'd0, tx_req}, 16'd1);
        chk("R11 addr", tx_addr, 16'h1200);
        chk("R11 len", tx_len, 16'h0140);
        cyc(0, 5'd0, 8'h00);
        chk("R11 one cycle", {15'd0, tx_req}, 16'd0);
        chk("R11 addr held", tx_addr, 16'h1200);
        rd(5'd0, v); chk("R11 tx bit cleared", {8'h0, v}, 16'h22);
        rd(5'd4, v); chk("R11 tstat", {8'h0, v}, 16'h01);
        rd(5'd7, v); chk("R11 isr txok", {8'h0, v}, 16'h02);
        chk("R8 irq tx", {15'd0, irq}, 16'd1);
        cyc(1, 5'd15, 8'h00);
        chk("R8 mask off", {15'd0, irq}, 16'd0);
        cyc(1, 5'd0, 8'h25);
        chk("R11 stopped no send", {15'd0, tx_req}, 16'd0);
        // R1 reset mid-run
        do_reset();
        rd(5'd0, v); chk("R1 cmd again", {8'h0, v}, 16'h22);
        rd(5'd7, v); chk("R1 isr again", {8'h0, v}, 16'h80);
        summary();
        $finish;
    end
endmodule